// File: doc/BRIEF.md
# Serial Converter Port

This block is the device-side serial port of an 8-bit multiplexed analog-to-digital converter. It runs entirely in the conversion clock domain. A host drives an active-low select, a serial clock and a data line, and reads a data output that has its own enable. The serial clock may be asynchronous to the conversion clock.

In each frame of eight serial clocks the host shifts in a 4-bit channel number and, in the same frame, reads the result of the previous conversion. After the eighth clock the port releases its output, holds the channel for the conversion engine, pulses a start request and ignores the serial clock until the engine reports completion. A completion flag from the engine loads the new result and raises the end-of-conversion output. If select stays low, the next frame can follow at once.

Select is filtered, so a brief low glitch does nothing. A low level that lasts long enough resets the frame, and it cancels a conversion that is still running.

Top module: `adc_serial_port`

## Requirements
- R1: After reset `sdo_en` is 0, `eoc` is 1, `conv_start` and `conv_abort` are 0, and the stored result is 0x00.
- R2: `sdo_en` is 0 while select is high. It drops within three conversion clocks of `cs_n` rising.
- R3: A low on `cs_n` lasting one conversion clock is ignored. A low lasting three or more clocks is accepted, and `sdo_en` then rises.
- R4: An accepted select resets the frame. The bit counters clear, and `sdo` shows bit 7 of the stored result, even when the previous frame was only partly done.
- R5: The stored result is sent on `sdo` with bit 7 first. The output moves to the next bit after each detected falling edge of `sclk`.
- R6: `sdi` is sampled on each of the first four detected rising edges of `sclk`, with the first sample as channel bit 3. The 4-bit channel appears on `conv_chan` with the start pulse and stays stable for the whole conversion.
- R7: The eighth detected falling edge of `sclk` drops `sdo_en` and `eoc` one clock after detection, whatever the state of select. In that same cycle `conv_start` is high for exactly one clock.
- R8: While a conversion runs, edges on `sclk` have no effect on the shift state or on the outputs.
- R9: `conv_done` during a conversion stores `conv_result` and raises `eoc`. If select is still low, the next frame starts with the new result.
- R10: A select acceptance during a conversion pulses `conv_abort` for one clock and raises `eoc`, and the previously stored result is kept.
- R11: If select is accepted in the same cycle as `conv_done`, the result is stored and no abort is issued.
- R12: `conv_done` while no conversion runs is ignored, and the stored result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from host (asynchronous) |
| sclk | input | 1 | Serial clock from host (asynchronous) |
| sdi | input | 1 | Serial channel number from host |
| sdo | output | 1 | Serial result bit |
| sdo_en | output | 1 | Output enable for sdo (0 = high impedance) |
| eoc | output | 1 | End of conversion, low while converting |
| conv_start | output | 1 | One-clock start request to the engine |
| conv_abort | output | 1 | One-clock cancel request to the engine |
| conv_chan | output | 4 | Channel held for the engine |
| conv_done | input | 1 | Engine completion pulse |
| conv_result | input | 8 | Engine result, valid with conv_done |

## Verification
Two functions can fall in the same cycle: the engine's completion and a select acceptance that would cancel the conversion. The bench aligns these by counting synchronizer and filter stages. It drives `cs_n` low and then raises `conv_done` exactly three clocks later, which is the cycle in which the filter accepts. The outcome is judged at the ports: no abort pulse may appear, and the next frame must read back the value delivered with that completion. A completion that arrives while the port is idle is also checked, by reading the next frame.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RES_W   = 8,
  parameter int ADDR_W  = 4,
  parameter int CS_FILT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_en,
  output logic              eoc,
  output logic              conv_start,
  output logic              conv_abort,
  output logic [ADDR_W-1:0] conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result
);
  localparam int CW = $clog2(RES_W + 1);
  localparam int FW = $clog2(CS_FILT + 1);

  logic [1:0]        cs_sy;
  logic [2:0]        sc_sy;
  logic [1:0]        sd_sy;
  logic [FW-1:0]     low_cnt;
  logic              cs_act;
  logic              busy;
  logic [CW-1:0]     rise_cnt, fall_cnt;
  logic [ADDR_W-1:0] addr_sr, chan_q;
  logic [RES_W-1:0]  tx_sr, result_q;
  logic              start_q, abort_q;

  logic cs_s, sc_rise, sc_fall, sd_s, accept, live, last_fall;

  assign cs_s      = cs_sy[1];
  assign sc_rise   = sc_sy[1] & ~sc_sy[2];
  assign sc_fall   = ~sc_sy[1] & sc_sy[2];
  assign sd_s      = sd_sy[1];
  assign accept    = ~cs_s & ~cs_act & (low_cnt == FW'(CS_FILT - 1));
  assign live      = cs_act & ~busy;
  assign last_fall = sc_fall & (fall_cnt == CW'(RES_W - 1));

  assign sdo        = tx_sr[RES_W-1];
  assign sdo_en     = live;
  assign eoc        = ~busy;
  assign conv_start = start_q;
  assign conv_abort = abort_q;
  assign conv_chan  = chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= 2'b11;
      sc_sy <= '0;
      sd_sy <= '0;
    end else begin
      cs_sy <= {cs_sy[0], cs_n};
      sc_sy <= {sc_sy[1:0], sclk};
      sd_sy <= {sd_sy[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      cs_act  <= 1'b0;
    end else if (cs_s) begin
      low_cnt <= '0;
      cs_act  <= 1'b0;
    end else if (!cs_act) begin
      if (low_cnt == FW'(CS_FILT - 1)) cs_act <= 1'b1;
      else low_cnt <= low_cnt + FW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rise_cnt <= '0;
      fall_cnt <= '0;
      addr_sr  <= '0;
      chan_q   <= '0;
      tx_sr    <= '0;
      result_q <= '0;
      start_q  <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      abort_q <= 1'b0;
      if (accept) begin
        rise_cnt <= '0;
        fall_cnt <= '0;
        busy     <= 1'b0;
        abort_q  <= busy & ~conv_done;
        if (busy & conv_done) begin
          result_q <= conv_result;
          tx_sr    <= conv_result;
        end else begin
          tx_sr <= result_q;
        end
      end else if (busy) begin
        if (conv_done) begin
          busy     <= 1'b0;
          result_q <= conv_result;
          tx_sr    <= conv_result;
          rise_cnt <= '0;
          fall_cnt <= '0;
        end
      end else if (cs_act) begin
        if (sc_rise && rise_cnt < CW'(ADDR_W)) begin
          addr_sr  <= {addr_sr[ADDR_W-2:0], sd_s};
          rise_cnt <= rise_cnt + CW'(1);
        end
        if (sc_fall) begin
          if (last_fall) begin
            busy     <= 1'b1;
            start_q  <= 1'b1;
            chan_q   <= addr_sr;
            fall_cnt <= '0;
          end else begin
            tx_sr    <= {tx_sr[RES_W-2:0], 1'b0};
            fall_cnt <= fall_cnt + CW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int RES_W  = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              busy,
  input logic              sdo_en,
  input logic              eoc,
  input logic              conv_start,
  input logic              conv_abort,
  input logic [ADDR_W-1:0] conv_chan,
  input logic              conv_done,
  input logic [RES_W-1:0]  result_q
);
  AST_CS_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n) cs_s |=> !sdo_en); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) conv_start |=> !conv_start); // R7
  AST_START_EOC_LOW: assert property (@(posedge clk) disable iff (!rst_n) conv_start |-> !eoc); // R7
  AST_HIZ_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !eoc |-> !sdo_en); // R8
  AST_CHAN_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(conv_chan)); // R6
  AST_ABORT_ENDS_CONV: assert property (@(posedge clk) disable iff (!rst_n) conv_abort |-> (eoc && !$past(eoc))); // R10
  AST_IDLE_DONE_NOP: assert property (@(posedge clk) disable iff (!rst_n) (conv_done && !busy) |=> $stable(result_q)); // R12
endmodule

bind adc_serial_port adc_serial_port_chk #(.RES_W(RES_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .busy(busy), .sdo_en(sdo_en), .eoc(eoc),
  .conv_start(conv_start), .conv_abort(conv_abort), .conv_chan(conv_chan),
  .conv_done(conv_done), .result_q(result_q)
);

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 2;
  localparam int LAT = 20;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic sdo, sdo_en, eoc, conv_start, conv_abort;
  logic [3:0] conv_chan;
  logic conv_done = 0;
  logic [7:0] conv_result = 0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .eoc(eoc), .conv_start(conv_start),
    .conv_abort(conv_abort), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // engine stand-in
  bit eng_en = 1;
  int eng_cnt = 0, man_delay = 0, n_start = 0, n_abort = 0;
  logic [7:0] eng_val = 0, man_val = 0, last_val = 0;
  logic [3:0] last_chan = 0;
  bit en_seen = 0;

  always @(negedge clk) begin
    conv_done = 0;
    if (man_delay > 0) begin
      man_delay--;
      if (man_delay == 0) begin conv_done = 1; conv_result = man_val; end
    end
    if (conv_abort) begin eng_cnt = 0; n_abort++; end
    if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin conv_done = 1; conv_result = eng_val; last_val = eng_val; end
    end
    if (conv_start) begin
      last_chan = conv_chan;
      n_start++;
      if (eng_en) begin
        eng_cnt = LAT;
        eng_val = 8'((int'(conv_chan) * 29 + n_start * 7 + 17) & 255);
      end
    end
    if (sdo_en) en_seen = 1;
  end

  // behavioural reference model, advanced on each rising clock edge
  bit cs_h[$], sc_h[$], sd_h[$];
  int m_low = 0, m_nr = 0, m_nf = 0;
  bit m_act = 0, m_busy = 0, m_start = 0, m_abort = 0;
  int m_addr = 0, m_chan = 0, m_word = 0, m_res = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      cs_h = {1'b1, 1'b1}; sc_h = {1'b0, 1'b0, 1'b0}; sd_h = {1'b0, 1'b0};
      m_low = 0; m_nr = 0; m_nf = 0; m_act = 0; m_busy = 0; m_start = 0; m_abort = 0;
      m_addr = 0; m_chan = 0; m_word = 0; m_res = 0;
    end else begin
      bit cs_s, rise, fall, sd, acc, was_busy, was_act;
      cs_s = cs_h[1]; rise = sc_h[1] && !sc_h[2]; fall = !sc_h[1] && sc_h[2]; sd = sd_h[1];
      acc = !cs_s && !m_act && (m_low == FILT - 1);
      was_busy = m_busy; was_act = m_act;
      m_start = 0; m_abort = 0;
      if (cs_s) begin m_low = 0; m_act = 0; end
      else if (!m_act) begin
        if (m_low == FILT - 1) m_act = 1; else m_low++;
      end
      if (acc) begin
        m_nr = 0; m_nf = 0; m_busy = 0;
        m_abort = was_busy && !conv_done;
        if (was_busy && conv_done) m_res = conv_result;
        m_word = m_res;
      end else if (was_busy) begin
        if (conv_done) begin m_busy = 0; m_res = conv_result; m_word = m_res; m_nr = 0; m_nf = 0; end
      end else if (was_act) begin
        if (rise && m_nr < 4) begin m_addr = ((m_addr << 1) | int'(sd)) & 15; m_nr++; end
        if (fall) begin
          if (m_nf == 7) begin m_busy = 1; m_start = 1; m_chan = m_addr; m_nf = 0; end
          else m_nf++;
        end
      end
      void'(cs_h.pop_back()); cs_h.push_front(cs_n);
      void'(sc_h.pop_back()); sc_h.push_front(sclk);
      void'(sd_h.pop_back()); sd_h.push_front(sdi);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_en;
      e_en = m_act && !m_busy;
      chk(sdo_en == e_en, "R2 sdo_en", sdo_en, e_en);
      chk(eoc == !m_busy, "R7 eoc", eoc, !m_busy);
      chk(conv_start == m_start, "R7 conv_start", conv_start, m_start);
      chk(conv_abort == m_abort, "R10 conv_abort", conv_abort, m_abort);
      chk(int'(conv_chan) == m_chan, "R6 conv_chan", conv_chan, m_chan);
      if (e_en) chk(int'(sdo) == ((m_word >> (7 - m_nf)) & 1), "R5 sdo", sdo, (m_word >> (7 - m_nf)) & 1);
    end
  end

  task automatic sclk_cycles(input int n, input logic [3:0] addr, output logic [7:0] rx);
    rx = 0;
    for (int b = 0; b < n; b++) begin
      sdi = (b < 4) ? addr[3-b] : 1'b0;
      rx = {rx[6:0], sdo};
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic wait_eoc;
    for (int i = 0; i < 200 && !eoc; i++) @(negedge clk);
  endtask

  task automatic cs_pulse_accept;
    cs_n = 1;
    repeat (3) @(negedge clk);
    cs_n = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rx, val1, val2;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sdo_en == 0, "R1 sdo_en", sdo_en, 0);
    chk(eoc == 1, "R1 eoc", eoc, 1);
    chk(conv_start == 0 && conv_abort == 0, "R1 start/abort", {conv_start, conv_abort}, 0);

    // R3: one-clock glitch ignored
    cs_n = 0; @(negedge clk); cs_n = 1;
    repeat (8) @(negedge clk);
    chk(!en_seen, "R3 glitch", en_seen, 0);
    chk(sdo_en == 0, "R2 idle", sdo_en, 0);

    cs_n = 0;
    repeat (6) @(negedge clk);
    chk(sdo_en == 1, "R3 accepted", sdo_en, 1);
    chk(sdo == 0, "R4 first bit", sdo, 0);

    sclk_cycles(8, 4'h5, rx);
    chk(rx == 8'h00, "R1 R5 reset result", rx, 0);
    chk(sdo_en == 0 && eoc == 0, "R7 after 8th", {sdo_en, eoc}, 0);
    chk(last_chan == 4'h5, "R6 channel", last_chan, 5);

    // R8: serial clock during conversion
    sclk_cycles(2, 4'hF, rx);
    wait_eoc;
    val1 = last_val;
    chk(eoc == 1, "R9 eoc high", eoc, 1);
    @(negedge clk);
    chk(sdo_en == 1, "R9 re-enable", sdo_en, 1);

    sclk_cycles(8, 4'h9, rx);
    chk(rx == val1, "R5 R8 R9 result", rx, val1);
    chk(last_chan == 4'h9, "R6 channel 2", last_chan, 9);
    wait_eoc;
    val2 = last_val;
    @(negedge clk);

    // R4: partial frame then reset
    sclk_cycles(3, 4'h2, rx);
    cs_pulse_accept;
    chk(sdo == val2[7], "R4 msb after reset", sdo, val2[7]);
    eng_en = 0;
    sclk_cycles(8, 4'hC, rx);
    chk(rx == val2, "R4 full frame", rx, val2);

    // R10: abort
    cs_n = 1;
    repeat (3) @(negedge clk);
    chk(sdo_en == 0, "R2 cs high", sdo_en, 0);
    cs_n = 0;
    repeat (6) @(negedge clk);
    chk(n_abort == 1, "R10 abort count", n_abort, 1);
    chk(eoc == 1, "R10 eoc", eoc, 1);
    sclk_cycles(8, 4'h1, rx);
    chk(rx == val2, "R10 result kept", rx, val2);

    // R11: accept coincides with done
    cs_n = 1;
    repeat (3) @(negedge clk);
    cs_n = 0;
    @(posedge clk);
    man_val = 8'h3C; man_delay = 3;
    repeat (8) @(negedge clk);
    chk(n_abort == 1, "R11 no abort", n_abort, 1);
    chk(eoc == 1, "R11 eoc", eoc, 1);
    sclk_cycles(8, 4'h4, rx);
    chk(rx == 8'h3C, "R11 result", rx, 8'h3C);

    // R12: done while idle
    cs_pulse_accept;
    chk(n_abort == 2, "R10 second abort", n_abort, 2);
    @(posedge clk);
    man_val = 8'hAA; man_delay = 1;
    repeat (4) @(negedge clk);
    eng_en = 1;
    sclk_cycles(8, 4'h6, rx);
    chk(rx == 8'h3C, "R12 ignored done", rx, 8'h3C);
    wait_eoc;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule